// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block finds the divider settings of a display PLL that best approach a requested pixel clock. After a start pulse it steps through every combination of two feedback dividers (outer and inner), a reference divider and a post divider. For each candidate it computes the oscillator frequency and the resulting pixel clock with a shared multicycle divider, then rejects the candidate if any legality rule fails. Among the legal candidates it keeps the one closest to the request.

When the sweep ends, the engine pulses `done`. It then publishes the chosen dividers, the achieved pixel clock, a one-hot post-divider field and a packed frequency-parameter word that a PLL programming stage can use directly. A search takes some ten thousand cycles. A start pulse that arrives during a search is not accepted.

Top module: `pixclk_div_search`

## Requirements
- R1: A candidate is legal only if the outer feedback divider FA (10..20) is strictly greater than the inner one FB (5..9), the combined divider m = 5*(FA+2) + (FB+2) lies within 70..120, and the reference divider RD lies within 3..8.
- R2: The oscillator frequency is floor(96000*m/(RD+2)) kHz. A candidate whose oscillator frequency is outside 1,400,000..2,800,000 kHz is rejected.
- R3: The fixed post factor PF is 10 when the request is at most 270,000 kHz and 5 otherwise. The product p = PD*PF, with PD in 1..8, must lie within 5..80. `p2_is_10` reports the PF choice of the finished search (1 means 10).
- R4: The pixel clock is floor(VCO/p) kHz, and it must lie within 20,000..400,000 kHz. `pix_khz` reports the value of the chosen candidate.
- R5: The result is the legal candidate with the smallest absolute difference to the request. The sweep runs in ascending order with FA outermost, then FB, then RD, with PD innermost. Only a strictly smaller difference replaces the held candidate, so the earliest candidate wins a tie.
- R6: The error bound starts at the requested value. If no candidate beats it, `found` is 0 and `m1_o`, `m2_o`, `n_o`, `p1_onehot`, `pix_khz` and `fp_word` are all 0.
- R7: `fp_word` carries RD in bits 23:16, FA in bits 15:8 and FB in bits 7:0, each zero-extended.
- R8: `fp_word[25:24]` holds a band code for the chosen oscillator frequency: 1 for at least 1,900,000 and below 2,400,000; 2 for at least 2,500,000 and below 3,000,000; 3 for above 3,100,000; 0 otherwise.
- R9: `p1_onehot` has only bit PD-1 set.
- R10: `busy` is high from the cycle after an accepted start until completion. `done` is a one-cycle pulse in the first cycle in which `busy` is low again. Result outputs change only together with `done`.
- R11: A start pulse while `busy` is high is ignored. The running search continues with its original request.
- R12: After reset, `busy`, `done`, `found` and `p2_is_10` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when idle |
| req_khz | input | FREQ_W | Requested pixel clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A legal candidate beat the request bound |
| p2_is_10 | output | 1 | Post factor chosen was 10 |
| m1_o | output | DIG_W | Chosen outer feedback divider |
| m2_o | output | DIG_W | Chosen inner feedback divider |
| n_o | output | DIG_W | Chosen reference divider |
| p1_onehot | output | 8 | One-hot post divider |
| pix_khz | output | FREQ_W | Achieved pixel clock in kHz |
| fp_word | output | 26 | Packed band and divider word |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a sweep with a different request. The bench issues such a pulse forty cycles into a search. It then checks that `busy` stays high and that the old results stay on the outputs. Finally it checks that the finished result matches the first request and not the intruding one. Expected results come from an arithmetic sweep over all 2640 combinations in the bench, run for requests on both sides of the PF threshold, exactly at it, at zero, below the reachable range and above it.

// File: rtl/pixclk_search_pkg.sv
package pixclk_search_pkg;
   localparam int REF_KHZ   = 96000;
   localparam int FA_LO     = 10;
   localparam int FA_HI     = 20;
   localparam int FB_LO     = 5;
   localparam int FB_HI     = 9;
   localparam int RD_LO     = 3;
   localparam int RD_HI     = 8;
   localparam int PD_LO     = 1;
   localparam int PD_HI     = 8;
   localparam int MSUM_LO   = 70;
   localparam int MSUM_HI   = 120;
   localparam int VCO_LO    = 1400000;
   localparam int VCO_HI    = 2800000;
   localparam int PTOT_LO   = 5;
   localparam int PTOT_HI   = 80;
   localparam int PIX_LO    = 20000;
   localparam int PIX_HI    = 400000;
   localparam int PF_SWITCH = 270000;
   localparam int PF_SLOW   = 10;
   localparam int PF_FAST   = 5;
   localparam int B1_LO     = 1900000;
   localparam int B1_HI     = 2400000;
   localparam int B2_LO     = 2500000;
   localparam int B2_HI     = 3000000;
   localparam int B3_ABOVE  = 3100000;
   localparam int FP_W      = 26;
   localparam int PD_OH_W   = PD_HI;
   localparam int NUM_DIG   = 4;
   localparam int MIN_FREQ_W = 24;

   typedef enum logic [2:0] {
      S_IDLE, S_EVAL, S_WVCO, S_VCHK, S_WPIX, S_CMP, S_NEXT
   } srch_state_t;
endpackage

// File: rtl/pixclk_sweep.sv
module pixclk_sweep
   import pixclk_search_pkg::*;
#(
   parameter int DIG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [DIG_W-1:0] pd,
   output logic [DIG_W-1:0] rd,
   output logic [DIG_W-1:0] fb,
   output logic [DIG_W-1:0] fa,
   output logic             last
);
   // digit 0 is innermost (PD), digit 3 outermost (FA)
   localparam int LO_T [NUM_DIG] = '{PD_LO, RD_LO, FB_LO, FA_LO};
   localparam int HI_T [NUM_DIG] = '{PD_HI, RD_HI, FB_HI, FA_HI};

   logic [NUM_DIG-1:0] wrap;
   logic [NUM_DIG-1:0] carry;

   always_comb begin
      carry[0] = adv;
      for (int i = 1; i < NUM_DIG; i++) carry[i] = carry[i-1] & wrap[i-1];
   end

   for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
      localparam logic [DIG_W-1:0] LOV = DIG_W'(LO_T[g]);
      localparam logic [DIG_W-1:0] HIV = DIG_W'(HI_T[g]);
      logic [DIG_W-1:0] val;
      assign wrap[g] = (val == HIV);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        val <= LOV;
         else if (clr)      val <= LOV;
         else if (carry[g]) val <= wrap[g] ? LOV : val + DIG_W'(1);
      end
   end

   assign pd   = g_dig[0].val;
   assign rd   = g_dig[1].val;
   assign fb   = g_dig[2].val;
   assign fa   = g_dig[3].val;
   assign last = &wrap;
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 7,
   parameter int BPC   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int STEPS = NUM_W / BPC;
   localparam int CNT_W = $clog2(STEPS + 1);

   if (NUM_W % BPC != 0) begin : g_bad_bpc
      $error("pixclk_divider: NUM_W must be a multiple of BPC");
   end

   logic [NUM_W-1:0] q, qn;
   logic [DEN_W:0]   r, rn;
   logic [DEN_W-1:0] d;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      qn = q;
      rn = r;
      for (int k = 0; k < BPC; k++) begin
         rn = {rn[DEN_W-1:0], qn[NUM_W-1]};
         qn = {qn[NUM_W-2:0], 1'b0};
         if (rn >= {1'b0, d}) begin
            rn    = rn - {1'b0, d};
            qn[0] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0; r <= '0; d <= '0; cnt <= '0; done <= 1'b0;
      end else if (start) begin
         q <= num; r <= '0; d <= den; cnt <= CNT_W'(STEPS); done <= 1'b0;
      end else if (cnt != '0) begin
         q    <= qn;
         r    <= rn;
         cnt  <= cnt - CNT_W'(1);
         done <= (cnt == CNT_W'(1));
      end else begin
         done <= 1'b0;
      end
   end

   assign quo = q;
endmodule

// File: rtl/pixclk_fp_pack.sv
module pixclk_fp_pack
   import pixclk_search_pkg::*;
#(
   parameter int DIG_W  = 5,
   parameter int FREQ_W = 24
) (
   input  logic [DIG_W-1:0]   fa,
   input  logic [DIG_W-1:0]   fb,
   input  logic [DIG_W-1:0]   rd,
   input  logic [DIG_W-1:0]   pd,
   input  logic [FREQ_W-1:0]  vco,
   output logic [FP_W-1:0]    fp,
   output logic [PD_OH_W-1:0] pd_oh
);
   localparam logic [FREQ_W-1:0] B1L = FREQ_W'(B1_LO);
   localparam logic [FREQ_W-1:0] B1H = FREQ_W'(B1_HI);
   localparam logic [FREQ_W-1:0] B2L = FREQ_W'(B2_LO);
   localparam logic [FREQ_W-1:0] B2H = FREQ_W'(B2_HI);
   localparam logic [FREQ_W-1:0] B3A = FREQ_W'(B3_ABOVE);

   logic [1:0] band;

   always_comb begin
      if (vco >= B1L && vco < B1H)      band = 2'd1;
      else if (vco >= B2L && vco < B2H) band = 2'd2;
      else if (vco > B3A)               band = 2'd3;
      else                              band = 2'd0;
   end

   assign fp = {band, 8'(rd), 8'(fa), 8'(fb)};

   for (genvar g = 0; g < PD_OH_W; g++) begin : g_oh
      assign pd_oh[g] = (pd == DIG_W'(g + 1));
   end
endmodule

// File: rtl/pixclk_div_search.sv
module pixclk_div_search
   import pixclk_search_pkg::*;
#(
   parameter int FREQ_W  = 24,
   parameter int DIG_W   = 5,
   parameter int DIV_BPC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] req_khz,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic              p2_is_10,
   output logic [DIG_W-1:0]  m1_o,
   output logic [DIG_W-1:0]  m2_o,
   output logic [DIG_W-1:0]  n_o,
   output logic [7:0]        p1_onehot,
   output logic [FREQ_W-1:0] pix_khz,
   output logic [25:0]       fp_word
);
   localparam int DEN_W = 7;
   localparam int MS_W  = 8;

   if (FREQ_W < MIN_FREQ_W) begin : g_bad_freq
      $error("pixclk_div_search: FREQ_W too narrow for oscillator products");
   end
   if (DIG_W < 5 || DIG_W > 8) begin : g_bad_dig
      $error("pixclk_div_search: DIG_W must be 5..8");
   end

   localparam logic [DIG_W-1:0]  FAL = DIG_W'(FA_LO);
   localparam logic [DIG_W-1:0]  FAH = DIG_W'(FA_HI);
   localparam logic [DIG_W-1:0]  FBL = DIG_W'(FB_LO);
   localparam logic [DIG_W-1:0]  FBH = DIG_W'(FB_HI);
   localparam logic [DIG_W-1:0]  RDL = DIG_W'(RD_LO);
   localparam logic [DIG_W-1:0]  RDH = DIG_W'(RD_HI);
   localparam logic [DIG_W-1:0]  PDL = DIG_W'(PD_LO);
   localparam logic [DIG_W-1:0]  PDH = DIG_W'(PD_HI);
   localparam logic [MS_W-1:0]   MSL = MS_W'(MSUM_LO);
   localparam logic [MS_W-1:0]   MSH = MS_W'(MSUM_HI);
   localparam logic [DEN_W-1:0]  PTL = DEN_W'(PTOT_LO);
   localparam logic [DEN_W-1:0]  PTH = DEN_W'(PTOT_HI);
   localparam logic [FREQ_W-1:0] VCL = FREQ_W'(VCO_LO);
   localparam logic [FREQ_W-1:0] VCH = FREQ_W'(VCO_HI);
   localparam logic [FREQ_W-1:0] PXL = FREQ_W'(PIX_LO);
   localparam logic [FREQ_W-1:0] PXH = FREQ_W'(PIX_HI);
   localparam logic [FREQ_W-1:0] PFS = FREQ_W'(PF_SWITCH);
   localparam logic [FREQ_W-1:0] REF = FREQ_W'(REF_KHZ);

   srch_state_t state;

   logic [FREQ_W-1:0] req_q, best_err, best_pix, best_vco, vco_q, pix_q, err;
   logic              pf10_q, vco_ok_q;
   logic [DIG_W-1:0]  best_fa, best_fb, best_rd, best_pd;
   logic [DIG_W-1:0]  fa, fb, rd, pd;
   logic              last;
   logic [MS_W-1:0]   msum;
   logic [DEN_W-1:0]  ptot;
   logic              legal_md, pd_first, p_ok, pix_ok;
   logic              div_start, div_done, vco_path;
   logic [FREQ_W-1:0] div_num, div_quo;
   logic [DEN_W-1:0]  div_den;
   logic [FP_W-1:0]   pk_fp;
   logic [PD_OH_W-1:0] pk_oh;

   pixclk_sweep #(.DIG_W(DIG_W)) u_sweep (
      .clk(clk), .rst_n(rst_n),
      .clr(state == S_IDLE && start),
      .adv(state == S_NEXT && !last),
      .pd(pd), .rd(rd), .fb(fb), .fa(fa), .last(last)
   );

   assign msum = MS_W'(fa) * MS_W'(5) + MS_W'(fb) + MS_W'(12);
   assign legal_md = (fa > fb) && fa >= FAL && fa <= FAH && fb >= FBL && fb <= FBH
                  && msum >= MSL && msum <= MSH && rd >= RDL && rd <= RDH;
   assign pd_first = (pd == PDL);
   assign ptot     = DEN_W'(pd) * (pf10_q ? DEN_W'(PF_SLOW) : DEN_W'(PF_FAST));
   assign p_ok     = pd >= PDL && pd <= PDH && ptot >= PTL && ptot <= PTH;
   assign pix_ok   = pix_q >= PXL && pix_q <= PXH;
   assign err      = (req_q >= pix_q) ? req_q - pix_q : pix_q - req_q;

   assign vco_path  = (state == S_EVAL) && pd_first;
   assign div_start = ((state == S_EVAL) && legal_md && (pd_first || (vco_ok_q && p_ok)))
                   || ((state == S_VCHK) && vco_ok_q && p_ok);
   assign div_num   = vco_path ? FREQ_W'(msum) * REF : vco_q;
   assign div_den   = vco_path ? DEN_W'(rd) + DEN_W'(2) : ptot;

   pixclk_divider #(.NUM_W(FREQ_W), .DEN_W(DEN_W), .BPC(DIV_BPC)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start),
      .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
   );

   pixclk_fp_pack #(.DIG_W(DIG_W), .FREQ_W(FREQ_W)) u_pack (
      .fa(best_fa), .fb(best_fb), .rd(best_rd), .pd(best_pd),
      .vco(best_vco), .fp(pk_fp), .pd_oh(pk_oh)
   );

   assign busy = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         req_q <= '0; pf10_q <= 1'b0; best_err <= '0; best_pix <= '0; best_vco <= '0;
         best_fa <= '0; best_fb <= '0; best_rd <= '0; best_pd <= '0;
         vco_q <= '0; vco_ok_q <= 1'b0; pix_q <= '0;
         done <= 1'b0; found <= 1'b0; p2_is_10 <= 1'b0;
         m1_o <= '0; m2_o <= '0; n_o <= '0; p1_onehot <= '0; pix_khz <= '0; fp_word <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: if (start) begin
               req_q    <= req_khz;
               pf10_q   <= (req_khz <= PFS);
               best_err <= req_khz;
               best_pix <= '0; best_vco <= '0;
               best_fa  <= '0; best_fb <= '0; best_rd <= '0; best_pd <= '0;
               state    <= S_EVAL;
            end
            S_EVAL: begin
               if (div_start) state <= pd_first ? S_WVCO : S_WPIX;
               else           state <= S_NEXT;
            end
            S_WVCO: if (div_done) begin
               vco_q    <= div_quo;
               vco_ok_q <= div_quo >= VCL && div_quo <= VCH;
               state    <= S_VCHK;
            end
            S_VCHK: state <= div_start ? S_WPIX : S_NEXT;
            S_WPIX: if (div_done) begin
               pix_q <= div_quo;
               state <= S_CMP;
            end
            S_CMP: begin
               if (pix_ok && err < best_err) begin
                  best_err <= err; best_pix <= pix_q; best_vco <= vco_q;
                  best_fa <= fa; best_fb <= fb; best_rd <= rd; best_pd <= pd;
               end
               state <= S_NEXT;
            end
            S_NEXT: begin
               if (last) begin
                  state     <= S_IDLE;
                  done      <= 1'b1;
                  found     <= (best_pix != '0);
                  p2_is_10  <= pf10_q;
                  m1_o      <= best_fa;
                  m2_o      <= best_fb;
                  n_o       <= best_rd;
                  p1_onehot <= pk_oh;
                  pix_khz   <= best_pix;
                  fp_word   <= pk_fp;
               end else begin
                  state <= S_EVAL;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pixclk_div_search_chk.sv
module pixclk_div_search_chk #(
   parameter int FREQ_W = 24,
   parameter int DIG_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              found,
   input logic [DIG_W-1:0]  m1_o,
   input logic [DIG_W-1:0]  m2_o,
   input logic [DIG_W-1:0]  n_o,
   input logic [7:0]        p1_onehot,
   input logic [FREQ_W-1:0] pix_khz,
   input logic [25:0]       fp_word
);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_finish_signals_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_hold_results_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(fp_word) && $stable(pix_khz) && $stable(found) && $stable(p1_onehot)));

   p_busy_not_cut_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ($countones(p1_onehot) == 1));

   p_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (fp_word[15:8] == 8'(m1_o) && fp_word[7:0] == 8'(m2_o)
                 && fp_word[23:16] == 8'(n_o) && fp_word[15:8] > fp_word[7:0]));

   p_pix_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (pix_khz >= FREQ_W'(20000) && pix_khz <= FREQ_W'(400000)));

   p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (fp_word == '0 && pix_khz == '0 && p1_onehot == '0));
endmodule

bind pixclk_div_search pixclk_div_search_chk #(.FREQ_W(FREQ_W), .DIG_W(DIG_W)) u_chk (.*);

// File: tb/test_pixclk_div_search.sv
module test_pixclk_div_search;
   localparam int FREQ_W = 24;
   localparam int DIG_W  = 5;
   localparam int WD_CYC = 190000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [FREQ_W-1:0] req_khz = '0;
   logic              busy, done, found, p2_is_10;
   logic [DIG_W-1:0]  m1_o, m2_o, n_o;
   logic [7:0]        p1_onehot;
   logic [FREQ_W-1:0] pix_khz;
   logic [25:0]       fp_word;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   int prev_fp = 0;

   always #10 clk = ~clk;

   pixclk_div_search #(.FREQ_W(FREQ_W), .DIG_W(DIG_W), .DIV_BPC(4)) i_pixclk_div_search (
      .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz),
      .busy(busy), .done(done), .found(found), .p2_is_10(p2_is_10),
      .m1_o(m1_o), .m2_o(m2_o), .n_o(n_o), .p1_onehot(p1_onehot),
      .pix_khz(pix_khz), .fp_word(fp_word)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // arithmetic sweep straight from the rules R1..R5
   task automatic model(input int req, output int bfa, output int bfb, output int brd,
                        output int bpd, output int bpix, output int bvco);
      int pf, berr;
      pf = (req <= 270000) ? 10 : 5;
      berr = req;
      bfa = 0; bfb = 0; brd = 0; bpd = 0; bpix = 0; bvco = 0;
      for (int fa = 10; fa <= 20; fa++)
         for (int fb = 5; fb <= 9; fb++)
            for (int rd = 3; rd <= 8; rd++)
               for (int pd = 1; pd <= 8; pd++) begin
                  int m, vco, p, pix, e;
                  if (fa <= fb) continue;
                  m = 5 * (fa + 2) + (fb + 2);
                  if (m < 70 || m > 120) continue;
                  vco = (96000 * m) / (rd + 2);
                  if (vco < 1400000 || vco > 2800000) continue;
                  p = pd * pf;
                  if (p < 5 || p > 80) continue;
                  pix = vco / p;
                  if (pix < 20000 || pix > 400000) continue;
                  e = (req >= pix) ? req - pix : pix - req;
                  if (e < berr) begin
                     berr = e; bfa = fa; bfb = fb; brd = rd; bpd = pd; bpix = pix; bvco = vco;
                  end
               end
   endtask

   function automatic int band_of(input int v);
      if (v >= 1900000 && v < 2400000) return 1;
      if (v >= 2500000 && v < 3000000) return 2;
      if (v > 3100000) return 3;
      return 0;
   endfunction

   task automatic search(input int req, input bit poke);
      int efa, efb, erd, epd, epix, evco, efp, eoh;
      model(req, efa, efb, erd, epd, epix, evco);
      efp = (epix != 0) ? ((band_of(evco) << 24) | (erd << 16) | (efa << 8) | efb) : 0;
      eoh = (epd != 0) ? (1 << (epd - 1)) : 0;
      @(negedge clk);
      req_khz = FREQ_W'(req);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 busy after start", int'(busy), 1);
      if (poke) begin
         repeat (40) @(negedge clk);
         req_khz = FREQ_W'(25000);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R11 busy kept on second start", int'(busy), 1);
         chk("R10 old result held while busy", int'(fp_word), prev_fp);
      end
      while (!done) @(negedge clk);
      chk("R10 busy low with done", int'(busy), 0);
      chk("R6 found", int'(found), (epix != 0) ? 1 : 0);
      chk("R3 p2_is_10", int'(p2_is_10), (req <= 270000) ? 1 : 0);
      chk("R5 outer divider", int'(m1_o), efa);
      chk("R1 inner divider", int'(m2_o), efb);
      chk("R2 reference divider", int'(n_o), erd);
      chk("R9 one-hot post divider", int'(p1_onehot), eoh);
      chk("R4 pixel clock", int'(pix_khz), epix);
      chk("R7 packed low fields", int'(fp_word[23:0]), efp & 32'h00FF_FFFF);
      chk("R8 band field", int'(fp_word[25:24]), efp >>> 24);
      if (poke) chk("R11 result from first request", int'(pix_khz), epix);
      prev_fp = int'(fp_word);
      @(negedge clk);
      chk("R10 done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL R10 watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 busy after reset", int'(busy), 0);
      chk("R12 done after reset", int'(done), 0);
      chk("R12 found after reset", int'(found), 0);
      chk("R12 p2 after reset", int'(p2_is_10), 0);
      chk("R12 fp after reset", int'(fp_word), 0);
      chk("R12 pix after reset", int'(pix_khz), 0);
      chk("R12 onehot after reset", int'(p1_onehot), 0);

      search(25175, 1'b0);     // low request, PF = 10
      search(270000, 1'b0);    // threshold, PF still 10
      search(270001, 1'b0);    // just above, PF = 5
      search(108000, 1'b1);    // second start during busy
      search(0, 1'b0);         // bound zero: nothing found
      search(9000, 1'b0);      // below reachable range: nothing found
      search(1000000, 1'b0);   // above range: nearest legal top value

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule